// File: doc/BRIEF.md
# Word-Oriented I2C Master

This block is an I2C bus master that software drives through four 32-bit registers: a clock and pin-pair setup register, a command register, a status register and a data register. Software does not move single bits or bytes. It writes one command word that packs the 7-bit target address, the transfer direction, a byte count, an end-of-transfer code and a go bit. The block then produces the whole bus sequence on its own: START, address with direction, the data bytes with their acknowledge slots, and an optional STOP.

Data crosses the register interface four bytes at a time, and the first byte on the bus sits in the lowest byte of the word. For a write, software loads the first word before it issues the command. Each time the block needs a fresh word, it raises a hardware-ready flag and holds SCL low until the word arrives. For a read, the block collects bytes into a word, publishes it, and raises the same flag. It then waits, with SCL held low, until software reads the word, and only after that does it start the next group of four. A transfer that ends without STOP leaves SCL held low, and the next command opens with a repeated START. A typical use writes a single offset byte of 0 to address 0x50 and then reads a block of bytes back from that address.

Both bus lines are open-drain: the block only pulls a line low or releases it, and it samples the real line level. A base divider parameter and a 3-bit rate field set the SCL period.

Top module: `i2c_word_master`

## Requirements
- R1: After reset, both bus lines are released and the clock, status and data registers read 0.
- R2: The clock register (offset 0) keeps only bits 10:8 (rate) and 2:0 (pin pair), and reads back 0 in all other bits. The pin pair appears on `pair_sel`.
- R3: Each SCL high phase lasts 2*q cycles, where q = QDIV >> rate, with a floor of 1. Rate 0 is the slowest setting.
- R4: A command write to offset 1 with bit 30 set starts a transfer. Bit 0 selects read (1) or write (0), bits 7:1 hold the address, bits 24:16 hold the byte count, and bit 27 requests a STOP at the end. The bus carries START, then the address and direction bit, then the bytes MSB first, taken from the data register low byte first. START and STOP occur only at byte boundaries.
- R5: Status (offset 2) bit 9 reads 1 while a transfer runs. Bit 14 (complete) is set when a transfer ends and is cleared by the next accepted command.
- R6: On a read, each group of four received bytes is placed in the data register (offset 3) with the first byte in bits 7:0, and status bit 11 (hardware ready) is set.
- R7: When the byte count is not a multiple of four, the bytes of the final word past the count read as 0.
- R8: On a read, the master acknowledges every byte except the last one, which it does not acknowledge.
- R9: During a read, reading the data register clears bit 11. While bit 11 is pending at a word boundary, SCL stays low.
- R10: On a write of more than four bytes, bit 11 requests the next word. Writing the data register clears bit 11 and the transfer resumes with that word.
- R11: If no acknowledge follows the address or a written byte, status bit 10 (error) is set, a STOP is issued and bit 14 is set.
- R12: With bit 27 clear, the transfer ends with SCL held low and no STOP, and the next command begins with a repeated START.
- R13: A command written while a transfer runs is ignored, and the running transfer and its stored fields are left unchanged.
- R14: A byte count of 0 sends only the address phase and then ends normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the read-clears side effect) |
| reg_addr | input | 2 | Register select: 0 clock, 1 command, 2 status, 3 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| pair_sel | output | 3 | Selected pin pair |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |

## Verification
Most internal faults show up on the bus before they reach the status register. A wrong bit or byte pointer changes the bytes the bench's target model logs, or the acknowledge pattern it records, within the same byte time. A wrong quarter counter shifts the measured SCL high time at the first bus clock. Faults in the word-boundary handshake show up in one of two ways: SCL rises during a stall the bench deliberately stretches, or the ready bit fails to clear on the next status read. A faulty end-of-transfer path leaves the START and STOP counts off once the command completes.

// File: rtl/i2c_word_master.sv
module i2c_word_master #(
  parameter int QDIV = 625,
  parameter int CNTW = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [2:0]  pair_sel,
  output logic        scl_pull,
  output logic        sda_pull,
  input  logic        scl_in,
  input  logic        sda_in
);
  localparam int CW = $clog2(QDIV + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_WAIT, S_STOP} st_t;

  st_t            st;
  logic [2:0]     rate, pair, c_cyc;
  logic           c_rd;
  logic [6:0]     c_addr;
  logic [CNTW-1:0] c_cnt, k;
  logic [1:0]     q;
  logic [3:0]     bitn;
  logic           aphase, rdy, done_q, err_q, scl_low, sda_low;
  logic [7:0]     sh;
  logic [31:0]    asmw, dreg, asm_n;
  logic [CW-1:0]  cnt, qraw, qlen;

  assign qraw = CW'(QDIV >> rate);
  assign qlen = (qraw == '0) ? CW'(1) : qraw;

  wire busy    = (st != S_IDLE);
  wire rx      = !aphase && c_rd;
  wire stretch = (st == S_BIT) && !scl_low && !scl_in;
  wire tick    = (st == S_START || st == S_BIT || st == S_STOP) && cnt == '0 && !stretch;
  wire go      = reg_wr && reg_addr == 2'd1 && reg_wdata[30] && !busy;
  wire [CNTW-1:0] k_nx = k + 1'b1;
  wire last    = (k == c_cnt - 1'b1);
  wire end_stop = c_cyc[2];

  always_comb begin
    asm_n = asmw;
    asm_n[8*k[1:0] +: 8] = sh;
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[31], reg_wdata[29:28], reg_wdata[15:11], reg_wdata[7:3]};

  assign pair_sel = pair;
  assign scl_pull = scl_low;
  assign sda_pull = sda_low;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {21'b0, rate, 5'b0, pair};
      2'd1:    reg_rdata = {1'b0, busy, 2'b0, c_cyc, 9'(c_cnt), 8'b0, c_addr, c_rd};
      2'd2:    reg_rdata = {17'b0, done_q, 2'b0, rdy, err_q, busy, 9'b0};
      default: reg_rdata = dreg;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rate <= '0; pair <= '0; c_cyc <= '0; c_rd <= 1'b0;
      c_addr <= '0; c_cnt <= '0; k <= '0; q <= '0; bitn <= '0;
      aphase <= 1'b0; rdy <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      scl_low <= 1'b0; sda_low <= 1'b0; sh <= '0; asmw <= '0; dreg <= '0;
      cnt <= '0;
    end else begin
      if (st == S_IDLE || st == S_WAIT) cnt <= qlen - 1'b1;
      else if (!stretch) cnt <= (cnt == '0) ? qlen - 1'b1 : cnt - 1'b1;

      if (reg_wr && reg_addr == 2'd0) begin
        rate <= reg_wdata[10:8];
        pair <= reg_wdata[2:0];
      end
      if (reg_wr && reg_addr == 2'd3) begin
        dreg <= reg_wdata;
        rdy  <= 1'b0;
      end
      if (reg_rd && reg_addr == 2'd3 && c_rd) rdy <= 1'b0;

      if (go) begin
        c_rd   <= reg_wdata[0];
        c_addr <= reg_wdata[7:1];
        c_cnt  <= reg_wdata[16 +: CNTW];
        c_cyc  <= reg_wdata[27:25];
        st     <= S_START;
        q      <= '0;
        k      <= '0;
        aphase <= 1'b1;
        done_q <= 1'b0;
        err_q  <= 1'b0;
        rdy    <= 1'b0;
        asmw   <= '0;
      end

      if (tick) begin
        q <= q + 1'b1;
        case (st)
          S_START: case (q)
            2'd0: sda_low <= 1'b0;
            2'd1: scl_low <= 1'b0;
            2'd2: sda_low <= 1'b1;
            default: begin
              scl_low <= 1'b1;
              st      <= S_BIT;
              bitn    <= '0;
              sh      <= {c_addr, c_rd};
            end
          endcase
          S_STOP: case (q)
            2'd0: sda_low <= 1'b1;
            2'd1: scl_low <= 1'b0;
            2'd2: sda_low <= 1'b0;
            default: begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          endcase
          S_BIT: case (q)
            2'd0: begin
              if (bitn < 4'd8) sda_low <= rx ? 1'b0 : !sh[7];
              else             sda_low <= rx ? !last : 1'b0;
            end
            2'd1: scl_low <= 1'b0;
            2'd2: ;
            default: begin
              scl_low <= 1'b1;
              if (bitn < 4'd8) begin
                sh   <= {sh[6:0], rx ? sda_in : 1'b0};
                bitn <= bitn + 1'b1;
              end else if (!rx && sda_in) begin
                err_q <= 1'b1;
                st    <= S_STOP;
              end else if (aphase) begin
                aphase <= 1'b0;
                if (c_cnt == '0) begin
                  if (end_stop) st <= S_STOP;
                  else begin st <= S_IDLE; done_q <= 1'b1; end
                end else begin
                  bitn <= '0;
                  sh   <= c_rd ? 8'h00 : dreg[7:0];
                end
              end else begin
                if (rx) asmw <= asm_n;
                if (k_nx == c_cnt) begin
                  if (rx) begin dreg <= asm_n; rdy <= 1'b1; end
                  if (end_stop) st <= S_STOP;
                  else begin st <= S_IDLE; done_q <= 1'b1; end
                end else if (k_nx[1:0] == 2'd0) begin
                  if (rx) begin dreg <= asm_n; asmw <= '0; end
                  rdy <= 1'b1;
                  k   <= k_nx;
                  st  <= S_WAIT;
                end else begin
                  k    <= k_nx;
                  bitn <= '0;
                  sh   <= c_rd ? 8'h00 : dreg[8*k_nx[1:0] +: 8];
                end
              end
            end
          endcase
          default: ;
        endcase
      end else if (st == S_WAIT && !rdy) begin
        st   <= S_BIT;
        bitn <= '0;
        q    <= '0;
        sh   <= c_rd ? 8'h00 : dreg[7:0];
      end
    end
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !scl_low) |-> !sda_low);
  a_r4_sda_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && !scl_low && !$past(scl_low)) |-> $stable(sda_low));
  a_r5_done_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st == S_IDLE));
  a_r9_wait_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> scl_low);
  a_r11_error_then_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (st == S_STOP));
  a_r13_busy_cmd_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd1) |=> ($stable(c_cnt) && $stable(c_addr) && $stable(c_rd)));
endmodule

// File: tb/tb_i2c_word_master.sv
module tb_i2c_word_master;
  localparam int QD = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [2:0] pair_sel;
  logic scl_pull, sda_pull, scl_line, sda_line;
  logic slv_low = 1'b0;

  always #2 clk = ~clk;

  assign scl_line = !scl_pull;
  assign sda_line = !(sda_pull || slv_low);

  i2c_word_master #(.QDIV(QD), .CNTW(9)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pair_sel(pair_sel),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .scl_in(scl_line), .sda_in(sda_line));

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input int i);
    return 8'(8'h30 + i * 5);
  endfunction

  function automatic logic [31:0] mkcmd(input bit rd, input logic [6:0] a, input int n, input bit stp, input bit g);
    return (32'(g) << 30) | (32'(stp) << 27) | (32'(n) << 16) | (32'(a) << 1) | 32'(rd);
  endfunction

  // behavioural target model, evaluated every clock on the falling edge
  typedef enum int {P_IDLE, P_ADDR, P_WR, P_RD} ph_t;
  ph_t phase = P_IDLE;
  int bitc = 0, nstarts = 0, nstops = 0, perr = 0;
  logic [7:0] sr = '0;
  logic [3:0] ptr = '0;
  bit rw = 0, first = 0, lastack = 0, pscl = 1, psda = 1;
  logic [7:0] wq[$];
  bit mq[$];

  always @(negedge clk) begin
    if (!rst_n) begin
      phase = P_IDLE; bitc = 0; slv_low <= 1'b0;
    end else if (scl_line && pscl && psda && !sda_line) begin
      nstarts++;
      if (bitc > 0 && bitc < 8) perr++;
      phase = P_ADDR; bitc = -1; slv_low <= 1'b0;
    end else if (scl_line && pscl && !psda && sda_line) begin
      nstops++;
      if (bitc > 0 && bitc < 8) perr++;
      phase = P_IDLE; slv_low <= 1'b0;
    end else if (!pscl && scl_line) begin
      if (bitc >= 0 && bitc < 8 && phase != P_RD) sr = {sr[6:0], sda_line};
      if (bitc == 8 && phase == P_RD) begin lastack = !sda_line; mq.push_back(!sda_line); end
    end else if (pscl && !scl_line && phase != P_IDLE) begin
      if (bitc == -1) bitc = 0;
      else if (bitc < 7) begin
        bitc++;
        if (phase == P_RD) slv_low <= !mbyte(int'(ptr))[7 - bitc];
      end else if (bitc == 7) begin
        bitc = 8;
        if (phase == P_ADDR) begin
          if (sr[7:1] == 7'h50) begin slv_low <= 1'b1; rw = sr[0]; first = 1; lastack = 1; end
          else begin slv_low <= 1'b0; phase = P_IDLE; end
        end else if (phase == P_WR) begin
          wq.push_back(sr);
          if (first) ptr = sr[3:0];
          first = 0;
          slv_low <= 1'b1;
        end else begin
          slv_low <= 1'b0;
          ptr = ptr + 1'b1;
        end
      end else begin
        bitc = 0;
        if (phase == P_ADDR) phase = rw ? P_RD : P_WR;
        if (phase == P_RD && lastack) slv_low <= !mbyte(int'(ptr))[7];
        else begin
          slv_low <= 1'b0;
          if (phase == P_RD) phase = P_IDLE;
        end
      end
    end
    pscl = scl_line;
    psda = sda_line;
  end

  // SCL high-time monitor, window restarted by bumping win_id
  int win_id = 0, win_seen = 0, hrun = 0, hmin = 0, hmax = 0;
  bit hvalid = 0, hp = 1;
  always @(negedge clk) begin
    if (win_seen != win_id) begin
      win_seen = win_id; hvalid = 0; hmin = 1000000; hmax = 0;
    end else begin
      if (scl_line && !hp) begin hvalid = 1; hrun = 1; end
      else if (scl_line && hvalid) hrun++;
      if (!scl_line && hp && hvalid) begin
        if (hrun < hmin) hmin = hrun;
        if (hrun > hmax) hmax = hrun;
      end
    end
    hp = scl_line;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_bit(input int b, input string req);
    logic [31:0] s = '0;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd2, s);
      if (s[b]) break;
    end
    chk(s[b], req, s, 32'(1) << b);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int st0, sp0, nq, highs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(scl_line && sda_line, "R1 lines released", {scl_line, sda_line}, 2'b11);
    rd(2'd2, v); chk(v == 0, "R1 status zero", v, 0);
    rd(2'd0, v); chk(v == 0, "R1 clock reg zero", v, 0);
    rd(2'd3, v); chk(v == 0, "R1 data zero", v, 0);

    // R2 clock register fields
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk(v == 32'h0000_0707, "R2 clock readback", v, 32'h707);
    chk(pair_sel == 3'd7, "R2 pair_sel", pair_sel, 7);
    wr(2'd0, 32'h0000_0005);
    chk(pair_sel == 3'd5, "R2 pair_sel update", pair_sel, 5);
    wr(2'd0, 32'h0);

    // R4 R5 R3: offset byte 0 written to 0x50 with STOP, rate 0
    sp0 = nstops;
    win_id++;
    wr(2'd3, 32'h0);
    wr(2'd1, mkcmd(0, 7'h50, 1, 1, 1));
    rd(2'd2, v); chk(v[9] && !v[14], "R5 busy while running", v, 32'h200);
    wait_bit(14, "R5 complete set");
    rd(2'd2, v); chk(v == 32'h4000, "R5 status after write", v, 32'h4000);
    chk(wq.size() == 1 && wq[0] == 8'h00, "R4 offset byte on bus", wq.size(), 1);
    chk(nstops == sp0 + 1, "R4 stop issued", nstops - sp0, 1);
    chk(hmin == 2 * QD && hmax == 2 * QD, "R3 SCL high at rate 0", hmax, 2 * QD);

    // R6 R7 R8 R9: six-byte read with a deliberate stall
    wr(2'd1, mkcmd(1, 7'h50, 6, 1, 1));
    wait_bit(11, "R6 first word ready");
    highs = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (scl_line) highs++; end
    chk(highs == 0, "R9 SCL held low while word pending", highs, 0);
    rd(2'd2, v); chk(v[11] && !v[14], "R9 still pending", v, 32'h0a00);
    rd(2'd3, v);
    chk(v == {mbyte(3), mbyte(2), mbyte(1), mbyte(0)}, "R6 first word", v,
        {mbyte(3), mbyte(2), mbyte(1), mbyte(0)});
    rd(2'd2, v); chk(!v[11], "R9 ready cleared by data read", v[11], 0);
    wait_bit(14, "R6 read complete");
    rd(2'd2, v); chk(v == 32'h4800, "R6 final status", v, 32'h4800);
    rd(2'd3, v);
    chk(v == {16'h0, mbyte(5), mbyte(4)}, "R7 partial word zero padded", v, {16'h0, mbyte(5), mbyte(4)});
    nq = mq.size();
    chk(nq == 6, "R8 ack slots seen", nq, 6);
    if (nq == 6)
      chk(mq[0] && mq[1] && mq[2] && mq[3] && mq[4] && !mq[5], "R8 ack pattern",
          {mq[0], mq[1], mq[2], mq[3], mq[4], mq[5]}, 6'b111110);

    // R10 R13: six-byte write, second command while busy
    wq.delete();
    wr(2'd3, 32'h4433_2211);
    wr(2'd1, mkcmd(0, 7'h50, 6, 1, 1));
    wr(2'd1, mkcmd(1, 7'h50, 1, 1, 1));
    wait_bit(11, "R10 next word requested");
    wr(2'd3, 32'h0000_6655);
    rd(2'd2, v); chk(!v[11], "R10 ready cleared by data write", v[11], 0);
    wait_bit(14, "R10 write complete");
    chk(wq.size() == 6, "R13 byte count kept", wq.size(), 6);
    if (wq.size() == 6)
      chk(wq[0] == 8'h11 && wq[1] == 8'h22 && wq[2] == 8'h33 && wq[3] == 8'h44 &&
          wq[4] == 8'h55 && wq[5] == 8'h66, "R10 write byte order",
          {wq[0], wq[1], wq[2], wq[3], wq[4], wq[5]}, 48'h112233445566);
    rd(2'd1, v); chk(v == mkcmd(0, 7'h50, 6, 1, 0), "R13 command fields kept", v, mkcmd(0, 7'h50, 6, 1, 0));

    // R11 address not acknowledged
    wq.delete(); sp0 = nstops;
    wr(2'd1, mkcmd(0, 7'h33, 2, 1, 1));
    wait_bit(14, "R11 complete after NACK");
    rd(2'd2, v); chk(v == 32'h4400, "R11 error status", v, 32'h4400);
    chk(nstops == sp0 + 1 && wq.size() == 0, "R11 stop and no data", nstops - sp0, 1);

    // R14 zero count
    sp0 = nstops;
    wr(2'd1, mkcmd(0, 7'h50, 0, 1, 1));
    wait_bit(14, "R14 complete");
    rd(2'd2, v); chk(v == 32'h4000, "R14 status", v, 32'h4000);
    chk(wq.size() == 0 && nstops == sp0 + 1, "R14 address only", wq.size(), 0);

    // R12 no STOP then repeated START
    sp0 = nstops; st0 = nstarts;
    wr(2'd3, 32'h0000_0002);
    wr(2'd1, mkcmd(0, 7'h50, 1, 0, 1));
    wait_bit(14, "R12 complete without stop");
    chk(nstops == sp0, "R12 no stop", nstops - sp0, 0);
    chk(!scl_line, "R12 SCL held low", scl_line, 0);
    wr(2'd1, mkcmd(1, 7'h50, 1, 1, 1));
    wait_bit(14, "R12 read after repeated start");
    chk(nstarts == st0 + 2 && nstops == sp0 + 1, "R12 repeated start", nstarts - st0, 2);
    rd(2'd3, v); chk(v == {24'h0, mbyte(2)}, "R12 read data", v, {24'h0, mbyte(2)});

    // R3 faster rate
    wr(2'd0, 32'h0000_0200);
    win_id++;
    wr(2'd3, 32'h0);
    wr(2'd1, mkcmd(0, 7'h50, 1, 1, 1));
    wait_bit(14, "R3 transfer at rate 2");
    chk(hmin == 2 * (QD >> 2) && hmax == 2 * (QD >> 2), "R3 SCL high at rate 2", hmax, 2 * (QD >> 2));

    chk(perr == 0, "R4 START/STOP only at byte boundaries", perr, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule